// File: doc/BRIEF.md
# Shift-Out Master Data Buffer

This block is a four-byte staging buffer that sits between a host register port and a serial-bus byte engine. The host pushes bytes by writing the data register and pops them by reading it. The oldest byte is always presented at entry 0. Each pop moves the remaining bytes one place toward entry 0. The byte engine can load the buffer in one step with the bytes it received, and it can drain the buffer after it has shifted the bytes out to the bus. The engine sees every entry in parallel.

The fill state is a signed index: -1 means empty and DEPTH-1 means full. Two host-visible flags, has-data and full, are driven from the buffer. They change only when the index crosses particular edges, on a flush, or on an engine load. Any other operation leaves them as they are. Writing a mode-control value that has the flush bit set empties the buffer and zeroes its contents.

Top module: `mst_data_buf`

## Requirements
- R1: The buffer holds DEPTH (4) bytes. `level_o` reports the index plus one, in the range 0 to 4. After reset, `level_o` is 0, both flags are low, `host_rdata_o` is 0 and `eng_data_o` is all zero.
- R2: A host push when the level is below 4 stores the byte at position `level_o` and raises the level by one. A push at level 4 is dropped, and it leaves the level and every entry unchanged.
- R3: The push that takes the level from 0 to 1 sets `has_data_o`. The push that takes it from 3 to 4 sets `full_o`.
- R4: When the level is not 0, `host_rdata_o` shows entry 0 in the same cycle. A pop lowers the level by one and moves entries 1 to level-1 down one place, so pushed bytes come out in order.
- R5: A pop at level 4 clears `full_o`. A pop at level 1 clears `has_data_o`. A pop at any other level leaves both flags unchanged.
- R6: A mode-control write with bit 6 set sets the level to 0, zeroes all entries and clears both flags. A mode-control write with bit 6 clear has no effect.
- R7: An engine load with count n writes entries 0 to n-1 from `eng_data_i` (entry i at bits i*8 upward) and sets the level to n. A count above 4 is treated as 4. The load sets `has_data_o` when n>0 and `full_o` when n=4. It never clears either flag.
- R8: An engine drain sets the level to 0 and leaves the entries and both flags unchanged. `eng_data_o` always presents entry i at bits i*8 upward.
- R9: A pop at level 0 returns 0x00 and leaves the level and both flags unchanged.
- R10: Only one operation takes effect per cycle, in this priority order: flush, engine load, engine drain, host push, host pop. The lower-priority requests in that cycle are ignored.
- R11: An active-low asynchronous reset zeroes all entries and empties the buffer at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host data-register write (push) |
| host_wdata_i | input | DW | Byte pushed |
| host_rd_i | input | 1 | Host data-register read (pop) |
| host_rdata_o | output | DW | Entry 0, or 0 when empty |
| mode_wr_i | input | 1 | Mode-control register write |
| mode_wdata_i | input | DW | Mode-control value; bit FLUSH_BIT flushes |
| eng_load_i | input | 1 | Engine load of received bytes |
| eng_cnt_i | input | CW | Number of bytes loaded |
| eng_data_i | input | DEPTH*DW | Bytes loaded, entry i at bits i*DW |
| eng_drain_i | input | 1 | Engine has consumed the buffer |
| eng_data_o | output | DEPTH*DW | All entries, entry i at bits i*DW |
| level_o | output | CW | Index plus one (0 = empty) |
| has_data_o | output | 1 | Has-data flag |
| full_o | output | 1 | Full flag |

## Verification
A wrong index shows up at `level_o` on the first edge after the operation. It also shows up on `host_rdata_o` at the next pop, where a byte arrives out of order or a 0x00 appears where data was expected. A shift error stays hidden until the shifted entry reaches position 0, so the bench pops a full buffer down to empty. The flags are sticky across loads and drains, so a flag error can stay hidden for many cycles. The bench therefore checks the flags after each edge-crossing operation and after each operation that must leave them untouched.

// File: rtl/mdbuf_pkg.sv
package mdbuf_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH,
    OP_LOAD,
    OP_DRAIN,
    OP_PUSH,
    OP_POP
  } mdbuf_op_e;
endpackage

// File: rtl/mdbuf_ctrl.sv
module mdbuf_ctrl
  import mdbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 load_i,
  input  logic [CW-1:0]        cnt_i,
  input  logic                 drain_i,
  input  logic                 push_i,
  input  logic                 pop_i,
  output mdbuf_op_e            op_o,
  output logic [CW-1:0]        load_n_o,
  output logic signed [IW-1:0] idx_o
);
  localparam logic signed [IW-1:0] IdxEmpty = '1;
  localparam logic signed [IW-1:0] IdxTop   = IW'(DEPTH - 1);
  localparam logic [CW-1:0]        CntMax   = CW'(DEPTH);

  logic signed [IW-1:0] idx_q, idx_d;

  assign load_n_o = (cnt_i > CntMax) ? CntMax : cnt_i;

  always_comb begin
    if (flush_i)                        op_o = OP_FLUSH;
    else if (load_i)                    op_o = OP_LOAD;
    else if (drain_i)                   op_o = OP_DRAIN;
    else if (push_i && idx_q != IdxTop) op_o = OP_PUSH;
    else if (push_i)                    op_o = OP_NONE;  // push on full is dropped
    else if (pop_i && idx_q != IdxEmpty) op_o = OP_POP;
    else                                op_o = OP_NONE;
  end

  always_comb begin
    unique case (op_o)
      OP_FLUSH, OP_DRAIN: idx_d = IdxEmpty;
      OP_LOAD:            idx_d = IW'(int'(load_n_o) - 1);
      OP_PUSH:            idx_d = idx_q + IW'(1);
      OP_POP:             idx_d = idx_q - IW'(1);
      default:            idx_d = idx_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= IdxEmpty;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= IdxEmpty) && (idx_q <= IdxTop));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && idx_q == IdxTop && !flush_i && !load_i && !drain_i) |=> $stable(idx_q));

  assert_drain_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && !flush_i && !load_i) |=> (idx_q == IdxEmpty));
endmodule

// File: rtl/mdbuf_store.sv
module mdbuf_store
  import mdbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int IW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  mdbuf_op_e            op_i,
  input  logic signed [IW-1:0] idx_i,
  input  logic [CW-1:0]        load_n_i,
  input  logic [DW-1:0]        push_data_i,
  input  logic [DEPTH*DW-1:0]  load_data_i,
  output logic [DEPTH*DW-1:0]  ent_o
);
  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_d;
    always_comb begin
      ent_d = ent_q[g];
      unique case (op_i)
        OP_FLUSH: ent_d = '0;
        OP_LOAD:  if (g < int'(load_n_i)) ent_d = load_data_i[g*DW +: DW];
        OP_PUSH:  if (g == int'(idx_i) + 1) ent_d = push_data_i;
        OP_POP:   if (g < int'(idx_i)) ent_d = ent_q[(g + 1) % DEPTH];
        default:  ;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else         ent_q[g] <= ent_d;
    end
    assign ent_o[g*DW +: DW] = ent_q[g];
  end

  assert_flush_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FLUSH) |=> (ent_o == '0));

  assert_drain_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DRAIN) |=> $stable(ent_o));
endmodule

// File: rtl/mdbuf_flags.sv
module mdbuf_flags
  import mdbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  mdbuf_op_e            op_i,
  input  logic signed [IW-1:0] idx_i,
  input  logic [CW-1:0]        load_n_i,
  output logic                 has_data_o,
  output logic                 full_o
);
  localparam logic signed [IW-1:0] IdxEmpty = '1;
  localparam logic signed [IW-1:0] IdxTop   = IW'(DEPTH - 1);
  localparam logic signed [IW-1:0] IdxNearTop = IW'(DEPTH - 2);

  logic has_q, has_d, full_q, full_d;

  always_comb begin
    has_d  = has_q;
    full_d = full_q;
    unique case (op_i)
      OP_FLUSH: begin has_d = 1'b0; full_d = 1'b0; end
      OP_LOAD: begin
        if (load_n_i != '0)          has_d  = 1'b1;
        if (int'(load_n_i) == DEPTH) full_d = 1'b1;
      end
      OP_PUSH: begin
        if (idx_i == IdxEmpty)   has_d  = 1'b1;
        if (idx_i == IdxNearTop) full_d = 1'b1;
      end
      OP_POP: begin
        if (idx_i == '0)     has_d  = 1'b0;
        if (idx_i == IdxTop) full_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      has_q  <= has_d;
      full_q <= full_d;
    end
  end

  assign has_data_o = has_q;
  assign full_o     = full_q;

  assert_first_push_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && idx_i == IdxEmpty) |=> has_data_o);

  assert_last_pop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && idx_i == '0) |=> !has_data_o);

  assert_flush_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FLUSH) |=> (!has_data_o && !full_o));

  assert_load_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD && has_data_o) |=> has_data_o);
endmodule

// File: rtl/mst_data_buf.sv
module mst_data_buf
  import mdbuf_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int DW        = 8,
  parameter int FLUSH_BIT = 6,
  localparam int IW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic [DW-1:0]       host_wdata_i,
  input  logic                host_rd_i,
  output logic [DW-1:0]       host_rdata_o,
  input  logic                mode_wr_i,
  input  logic [DW-1:0]       mode_wdata_i,
  input  logic                eng_load_i,
  input  logic [CW-1:0]       eng_cnt_i,
  input  logic [DEPTH*DW-1:0] eng_data_i,
  input  logic                eng_drain_i,
  output logic [DEPTH*DW-1:0] eng_data_o,
  output logic [CW-1:0]       level_o,
  output logic                has_data_o,
  output logic                full_o
);
  localparam logic [DW-1:0] FlushMask = DW'(1) << FLUSH_BIT;

  mdbuf_op_e            op;
  logic signed [IW-1:0] idx;
  logic [CW-1:0]        load_n;
  logic                 flush_req;

  assign flush_req = mode_wr_i && ((mode_wdata_i & FlushMask) != '0);

  mdbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .flush_i (flush_req),
    .load_i  (eng_load_i),
    .cnt_i   (eng_cnt_i),
    .drain_i (eng_drain_i),
    .push_i  (host_wr_i),
    .pop_i   (host_rd_i),
    .op_o    (op),
    .load_n_o(load_n),
    .idx_o   (idx)
  );

  mdbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .op_i       (op),
    .idx_i      (idx),
    .load_n_i   (load_n),
    .push_data_i(host_wdata_i),
    .load_data_i(eng_data_i),
    .ent_o      (eng_data_o)
  );

  mdbuf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni,
    .op_i      (op),
    .idx_i     (idx),
    .load_n_i  (load_n),
    .has_data_o(has_data_o),
    .full_o    (full_o)
  );

  assign level_o      = CW'(int'(idx) + 1);
  assign host_rdata_o = (idx < 0) ? '0 : eng_data_o[DW-1:0];

  assert_empty_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && level_o == '0 && !flush_req && !eng_load_i && !eng_drain_i && !host_wr_i)
    |=> (level_o == '0 && $stable(has_data_o) && $stable(full_o)));

  assert_fifo_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && level_o > CW'(1) && !flush_req && !eng_load_i && !eng_drain_i && !host_wr_i)
    |=> (host_rdata_o == $past(eng_data_o[2*DW-1:DW])));
endmodule

// File: tb/tb_mst_data_buf.sv
module tb_mst_data_buf;
  localparam int DEPTH = 4;
  localparam int DW = 8;
  localparam int CW = 3;

  logic clk = 0, rst_ni = 0;
  logic host_wr = 0, host_rd = 0, mode_wr = 0, eng_load = 0, eng_drain = 0;
  logic [DW-1:0] host_wdata = '0, mode_wdata = '0, host_rdata;
  logic [CW-1:0] eng_cnt = '0, level;
  logic [DEPTH*DW-1:0] eng_din = '0, eng_dout;
  logic has_data, full;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  mst_data_buf dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .eng_load_i(eng_load), .eng_cnt_i(eng_cnt), .eng_data_i(eng_din),
    .eng_drain_i(eng_drain), .eng_data_o(eng_dout),
    .level_o(level), .has_data_o(has_data), .full_o(full)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req, int lvl, bit hd, bit fl);
    check({req, " level"}, 64'(level), 64'(lvl));
    check({req, " has_data"}, 64'(has_data), 64'(hd));
    check({req, " full"}, 64'(full), 64'(fl));
  endtask

  // one cycle of requests, driven at negedge, result visible at next negedge
  task automatic cyc(bit wr, logic [7:0] wd, bit rd, bit mw, logic [7:0] mwd,
                     bit ld, logic [2:0] n, logic [31:0] d, bit dr);
    @(negedge clk);
    host_wr = wr; host_wdata = wd; host_rd = rd; mode_wr = mw; mode_wdata = mwd;
    eng_load = ld; eng_cnt = n; eng_din = d; eng_drain = dr;
    @(negedge clk);
    host_wr = 0; host_rd = 0; mode_wr = 0; eng_load = 0; eng_drain = 0;
  endtask

  task automatic push(logic [7:0] b);  cyc(1, b, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic pop();                cyc(0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic flush();              cyc(0, 0, 0, 1, 8'h40, 0, 0, 0, 0); endtask
  task automatic load(logic [2:0] n, logic [31:0] d); cyc(0, 0, 0, 0, 0, 1, n, d, 0); endtask

  task automatic t_reset();
    check_state("R1 reset", 0, 0, 0);
    check("R1 reset rdata", 64'(host_rdata), 0);
    check("R11 reset entries", 64'(eng_dout), 0);
  endtask

  task automatic t_push_pop();
    push(8'hA1);
    check_state("R3 first push", 1, 1, 0);
    push(8'hB2); push(8'hC3);
    check_state("R3 three pushes", 3, 1, 0);
    push(8'hD4);
    check_state("R3 fourth push", 4, 1, 1);
    push(8'hE5);
    check_state("R2 push on full", 4, 1, 1);
    check("R2 entries", 64'(eng_dout), 64'h D4C3B2A1);
    check("R4 head", 64'(host_rdata), 64'hA1);
    pop();
    check_state("R5 pop at full", 3, 1, 0);
    check("R4 second", 64'(host_rdata), 64'hB2);
    pop();
    check("R4 third", 64'(host_rdata), 64'hC3);
    pop();
    check("R4 fourth", 64'(host_rdata), 64'hD4);
    check_state("R5 mid pop", 1, 1, 0);
    pop();
    check_state("R5 last pop", 0, 0, 0);
  endtask

  task automatic t_empty_pop();
    check("R9 empty rdata", 64'(host_rdata), 0);
    pop();
    check_state("R9 empty pop", 0, 0, 0);
    check("R9 rdata after", 64'(host_rdata), 0);
  endtask

  task automatic t_flush();
    push(8'h11); push(8'h22);
    cyc(0, 0, 0, 1, 8'hBF, 0, 0, 0, 0);
    check_state("R6 no flush bit", 2, 1, 0);
    check("R6 no flush data", 64'(host_rdata), 64'h11);
    flush();
    check_state("R6 flush", 0, 0, 0);
    check("R6 flush zeroes", 64'(eng_dout), 0);
  endtask

  task automatic t_load_drain();
    load(3, 32'h44332211);
    check_state("R7 load 3", 3, 1, 0);
    check("R7 load entries", 64'(eng_dout), 64'h00332211);
    check("R7 load head", 64'(host_rdata), 64'h11);
    load(4, 32'hD4C3B2A1);
    check_state("R7 load 4", 4, 1, 1);
    flush();
    load(0, 32'hFFFFFFFF);
    check_state("R7 load 0", 0, 0, 0);
    check("R7 load 0 entries", 64'(eng_dout), 0);
    load(7, 32'h44332211);
    check_state("R7 load clamp", 4, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    check_state("R8 drain", 0, 1, 1);
    check("R8 drain entries", 64'(eng_dout), 64'h44332211);
    check("R8 drain rdata", 64'(host_rdata), 0);
    load(1, 32'h000000EE);
    check_state("R7 load keeps full", 1, 1, 1);
  endtask

  task automatic t_priority();
    flush();
    push(8'h01);
    cyc(1, 8'h02, 1, 0, 0, 0, 0, 0, 0);
    check("R10 push over pop", 64'(level), 2);
    check("R10 head kept", 64'(host_rdata), 64'h01);
    cyc(1, 8'h03, 0, 1, 8'h40, 0, 0, 0, 0);
    check_state("R10 flush over push", 0, 0, 0);
    cyc(1, 8'h04, 0, 0, 0, 1, 2, 32'h0000BBAA, 1);
    check("R10 load over drain", 64'(level), 2);
    check("R10 load data", 64'(host_rdata), 64'hAA);
    cyc(1, 8'h05, 0, 0, 0, 0, 0, 0, 1);
    check("R10 drain over push", 64'(level), 0);
  endtask

  task automatic t_async_reset();
    flush();
    push(8'h77); push(8'h88);
    #1 rst_ni = 0;
    #1;
    check_state("R11 async reset", 0, 0, 0);
    check("R11 async entries", 64'(eng_dout), 0);
    @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    fork
      begin
        #(8 * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
      begin
        #20 rst_ni = 1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_empty_pop();
        t_flush();
        t_load_drain();
        t_priority();
        t_async_reset();
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule